// File: doc/BRIEF.md
# Register Write Command Packer

This block turns a stream of register-write requests into a list of commands in a dword-wide command memory. A later engine reads that list back and carries out the writes. Each request carries a 20-bit register offset, a 32-bit data word and a mode bit. The mode bit selects either a plain write or an indexed write.

A plain write becomes a two-dword command: the data dword first, then a header dword. An indexed write opens a new command on an 8-byte boundary. The command holds a count dword, a header dword and one data dword. Further indexed writes to the same register extend the open command: each appends a data dword and updates the count in place.

The packer drives the memory's write port and one read port, used for the count update. It reports how many dwords it has filled and a sticky overflow flag. A clear input rewinds it to an empty list.

Top module: `reg_write_packer`

## Requirements
- R1: A plain request accepted at fill level P writes its data at P, then a header at P+1, and the fill level becomes P+2. The header holds opcode 0x01 in bits 31:24, 0xF in bits 23:20 and the offset in bits 19:0.
- R2: An indexed request that does not extend the open command rounds the fill level up to an even index E. It writes the count value 1 at E, a header at E+1 and the data at E+2, and the fill level becomes E+3. The header holds opcode 0x09 in bits 31:24, zero in bits 23:20 and the offset in bits 19:0.
- R3: An indexed request with the same offset as the open indexed command writes its data at the fill level and advances the fill level by one. It then reads the count dword at the command start through the read port (one-cycle read latency) and writes back the count plus one.
- R4: When a request finishes with an odd fill level, a zero dword is written at the fill level, and the fill level does not change.
- R5: A plain request closes the open indexed command, so a following indexed request to the same offset starts a new command.
- R6: An indexed request with an offset different from the open command's starts a new command.
- R7: Memory writes appear one per cycle, in this order: data, header, pad for plain requests; count, header, data, pad for a new indexed command; data, count, pad for a merge. req_ready stays low from acceptance until the request's last write has been issued.
- R8: The fill level never decreases except through clear.
- R9: A request accepted while the fill level is at or above DEPTH produces no memory write and leaves the fill level unchanged. It sets overflow, which stays set until clear or reset. Any dword whose index is DEPTH or more is never written.
- R10: Clear sets the fill level and the command start to 0, closes the open command and drops overflow.
- R11: After reset, req_ready is 1, the fill level is 0, overflow is 0 and no memory write is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Rewind the command list to empty |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Packer can take a request |
| req_indexed | input | 1 | 1 = indexed write, 0 = plain write |
| req_offset | input | 20 | Register offset |
| req_data | input | 32 | Register data |
| mem_we | output | 1 | Command memory write enable |
| mem_addr | output | $clog2(DEPTH) | Command memory write index |
| mem_wdata | output | 32 | Command memory write data |
| mem_rd_addr | output | $clog2(DEPTH) | Command memory read index (count dword) |
| mem_rd_data | input | 32 | Command memory read data, one cycle after the address |
| fill_level | output | $clog2(DEPTH)+2 | Next free dword index |
| overflow | output | 1 | Sticky: a request was dropped for lack of space |

## Verification
The bench drives the packer with several kinds of input:
- plain writes from both even and odd fill levels, which separate the plain layout from the alignment that only indexed commands perform;
- a run of indexed writes to one offset, against a switch of offset and against an indexed write right after a plain one to the same offset, which separates merging from opening a new command and shows which events close a chain;
- a fill run past DEPTH, which shows both the suppression of out-of-range dwords and the dropping of whole requests;
- a clear followed by fresh indexed traffic, which shows that the start index and the chain state rewind along with the pointer.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
  localparam logic [7:0] OPC_PLAIN   = 8'h01;
  localparam logic [7:0] OPC_INDEXED = 8'h09;
  localparam logic [3:0] BYTES_ALL   = 4'hF;

  typedef enum logic [2:0] {
    S_IDLE, S_CNT1, S_HDR, S_DATA, S_WAIT, S_INC, S_PAD
  } step_t;

  typedef enum logic [1:0] {
    K_PLAIN, K_NEW, K_MERGE
  } kind_t;
endpackage

// File: rtl/rwp_chain.sv
module rwp_chain #(
  parameter int OFF_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             open_cmd,
  input  logic             close_cmd,
  input  logic [OFF_W-1:0] new_offset,
  input  logic [OFF_W-1:0] probe_offset,
  output logic             hit
);
  logic             open_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      open_q <= 1'b0;
      off_q  <= '0;
    end else if (open_cmd) begin
      open_q <= 1'b1;
      off_q  <= new_offset;
    end else if (close_cmd) begin
      open_q <= 1'b0;
    end
  end

  assign hit = open_q && (off_q == probe_offset);

  // R5: a plain request leaves no chain open behind it
  a_r5_close_chain: assert property (@(posedge clk) disable iff (rst)
    (close_cmd && !open_cmd && !clr) |=> !hit);
endmodule

// File: rtl/rwp_wport.sv
module rwp_wport #(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 32,
  parameter int PW     = 13
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [PW-1:0]             wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  output logic                      mem_we,
  output logic [$clog2(DEPTH)-1:0]  mem_addr,
  output logic [DATA_W-1:0]         mem_wdata
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [PW-1:0] LIMIT = PW'(DEPTH);

  logic in_range;
  assign in_range = wr_idx < LIMIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we <= 1'b0;
    end else begin
      mem_we <= wr_en && in_range;
    end
    mem_addr  <= wr_idx[AW-1:0];
    mem_wdata <= wr_data;
  end

  // R9: an index at or past the capacity never reaches the memory
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_range) |=> !mem_we);
endmodule

// File: rtl/rwp_seq.sv
module rwp_seq
  import rwp_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int OFF_W  = 20,
  parameter int DATA_W = 32,
  parameter int PW     = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_indexed,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_data,
  input  logic              chain_hit,
  output logic              open_cmd,
  output logic              close_cmd,
  output logic              wr_en,
  output logic [PW-1:0]     wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic [PW-1:0]     start_idx,
  input  logic [DATA_W-1:0] rd_data,
  output logic [PW-1:0]     fill_level,
  output logic              overflow
);
  localparam logic [PW-1:0] LIMIT = PW'(DEPTH);

  step_t             st;
  kind_t             kind;
  logic [PW-1:0]     ptr;
  logic [PW-1:0]     ptr_p1;
  logic [PW-1:0]     ptr_even;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] header;
  logic              accept;
  logic              full;

  assign req_ready  = (st == S_IDLE);
  assign accept     = req_ready && req_valid;
  assign full       = ptr >= LIMIT;
  assign ptr_p1     = ptr + PW'(1);
  assign ptr_even   = {ptr_p1[PW-1:1], 1'b0};
  assign fill_level = ptr;
  assign open_cmd   = accept && !full && req_indexed && !chain_hit;
  assign close_cmd  = accept && !full && !req_indexed;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st        <= S_IDLE;
      kind      <= K_PLAIN;
      ptr       <= '0;
      start_idx <= '0;
      overflow  <= 1'b0;
      off_q     <= '0;
      data_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          if (full) begin
            overflow <= 1'b1;
          end else begin
            off_q  <= req_offset;
            data_q <= req_data;
            if (!req_indexed) begin
              kind      <= K_PLAIN;
              start_idx <= ptr;
              st        <= S_DATA;
            end else if (chain_hit) begin
              kind <= K_MERGE;
              st   <= S_DATA;
            end else begin
              kind      <= K_NEW;
              ptr       <= ptr_even;
              start_idx <= ptr_even;
              st        <= S_CNT1;
            end
          end
        end
        S_CNT1: begin
          ptr <= ptr_p1;
          st  <= S_HDR;
        end
        S_HDR: begin
          ptr <= ptr_p1;
          st  <= (kind == K_PLAIN) ? S_PAD : S_DATA;
        end
        S_DATA: begin
          ptr <= ptr_p1;
          case (kind)
            K_PLAIN: st <= S_HDR;
            K_NEW:   st <= S_PAD;
            default: st <= S_WAIT;
          endcase
        end
        S_WAIT:  st <= S_INC;
        S_INC:   st <= S_PAD;
        S_PAD:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    header = '0;
    if (kind == K_PLAIN) begin
      header[DATA_W-1 -: 8] = OPC_PLAIN;
      header[DATA_W-9 -: 4] = BYTES_ALL;
    end else begin
      header[DATA_W-1 -: 8] = OPC_INDEXED;
    end
    header[OFF_W-1:0] = off_q;
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = ptr;
    wr_data = '0;
    case (st)
      S_CNT1: begin wr_en = 1'b1; wr_data = DATA_W'(1); end
      S_HDR:  begin wr_en = 1'b1; wr_data = header; end
      S_DATA: begin wr_en = 1'b1; wr_data = data_q; end
      S_INC:  begin wr_en = 1'b1; wr_idx = start_idx; wr_data = rd_data + DATA_W'(1); end
      S_PAD:  begin wr_en = ptr[0]; end
      default: ;
    endcase
  end

  // R2: a new indexed command always begins on an even dword index
  a_r2_even_start: assert property (@(posedge clk) disable iff (rst)
    (st == S_CNT1) |-> !ptr[0]);

  // R9: a request seen while full is dropped and flagged
  a_r9_drop: assert property (@(posedge clk) disable iff (rst)
    (accept && full && !clr) |=> (overflow && ptr == $past(ptr) && req_ready));

  // R10: clear empties the list and drops the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ptr == '0 && start_idx == '0 && !overflow && req_ready));

  // R8: the fill level only grows between clears
  a_r8_monotonic: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> ptr >= $past(ptr));
endmodule

// File: rtl/reg_write_packer.sv
module reg_write_packer #(
  parameter int DEPTH  = 2048,
  parameter int OFF_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_indexed,
  input  logic [OFF_W-1:0]           req_offset,
  input  logic [DATA_W-1:0]          req_data,
  output logic                       mem_we,
  output logic [$clog2(DEPTH)-1:0]   mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  output logic [$clog2(DEPTH)-1:0]   mem_rd_addr,
  input  logic [DATA_W-1:0]          mem_rd_data,
  output logic [$clog2(DEPTH)+1:0]   fill_level,
  output logic                       overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 2;

  logic              chain_hit;
  logic              open_cmd;
  logic              close_cmd;
  logic              wr_en;
  logic [PW-1:0]     wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic [PW-1:0]     start_idx;

  rwp_seq #(.DEPTH(DEPTH), .OFF_W(OFF_W), .DATA_W(DATA_W), .PW(PW)) u_seq (
    .clk(clk), .rst(rst), .clr(clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_indexed(req_indexed),
    .req_offset(req_offset), .req_data(req_data),
    .chain_hit(chain_hit), .open_cmd(open_cmd), .close_cmd(close_cmd),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .start_idx(start_idx), .rd_data(mem_rd_data),
    .fill_level(fill_level), .overflow(overflow)
  );

  rwp_chain #(.OFF_W(OFF_W)) u_chain (
    .clk(clk), .rst(rst), .clr(clr),
    .open_cmd(open_cmd), .close_cmd(close_cmd),
    .new_offset(req_offset), .probe_offset(req_offset), .hit(chain_hit)
  );

  rwp_wport #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PW(PW)) u_wport (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign mem_rd_addr = start_idx[AW-1:0];
endmodule

// File: tb/sim_reg_write_packer.sv
module sim_reg_write_packer;
  localparam int D  = 32;
  localparam int AW = $clog2(D);
  localparam int PW = AW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic req_valid = 1'b0;
  logic req_indexed = 1'b0;
  logic [19:0] req_offset = '0;
  logic [31:0] req_data = '0;
  logic req_ready, mem_we, overflow;
  logic [AW-1:0] mem_addr, mem_rd_addr;
  logic [31:0] mem_wdata, mem_rd_data;
  logic [PW-1:0] fill_level;

  always #2 clk = ~clk;

  reg_write_packer #(.DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .clr(clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_indexed(req_indexed),
    .req_offset(req_offset), .req_data(req_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .fill_level(fill_level), .overflow(overflow)
  );

  logic [31:0] mem_model [D];
  always @(posedge clk) begin
    if (mem_we) mem_model[mem_addr] <= mem_wdata;
    mem_rd_data <= mem_model[mem_rd_addr];
  end

  typedef struct { int idx; logic [31:0] val; string tag; } item_t;
  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_ptr = 0, m_start = 0, m_cnt = 0;
  bit m_open = 0, m_ovf = 0;
  logic [19:0] m_off = '0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (exp_q.size() == 0) begin
        check(0, "R7", "unexpected write index", mem_addr, -1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(mem_addr == AW'(it.idx), it.tag, "write index", mem_addr, it.idx);
        check(mem_wdata == it.val, it.tag, "write data", mem_wdata, it.val);
      end
    end
  end

  task automatic emit(int idx, logic [31:0] val, string tag);
    if (idx < D) exp_q.push_back('{idx, val, tag});
  endtask

  task automatic model(bit idx, logic [19:0] off, logic [31:0] dat, string tag);
    if (m_ptr >= D) begin
      m_ovf = 1;
      return;
    end
    if (!idx) begin
      m_start = m_ptr;
      emit(m_ptr, dat, tag);
      emit(m_ptr + 1, {8'h01, 4'hF, off}, tag);
      m_ptr += 2;
      m_open = 0;
    end else if (m_open && off == m_off) begin
      emit(m_ptr, dat, tag);
      m_ptr += 1;
      m_cnt += 1;
      emit(m_start, m_cnt, tag);
    end else begin
      m_ptr = (m_ptr + 1) & ~1;
      m_start = m_ptr;
      m_cnt = 1;
      emit(m_ptr, 32'd1, tag);
      emit(m_ptr + 1, {8'h09, 4'h0, off}, tag);
      emit(m_ptr + 2, dat, tag);
      m_ptr += 3;
      m_open = 1;
      m_off = off;
    end
    if (m_ptr % 2 == 1) emit(m_ptr, 32'd0, "R4");
  endtask

  task automatic send(bit idx, logic [19:0] off, logic [31:0] dat, string tag);
    model(idx, off, dat, tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_indexed = idx; req_offset = off; req_data = dat;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk); #1;
    check(exp_q.size() == 0, tag, "missing writes", exp_q.size(), 0);
    exp_q.delete();
    check(fill_level == PW'(m_ptr), "R8", "fill level", fill_level, m_ptr);
    check(overflow == m_ovf, "R9", "overflow", overflow, m_ovf);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R7", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R11 reset state
    check(req_ready == 1'b1, "R11", "ready", req_ready, 1);
    check(fill_level == '0, "R11", "fill", fill_level, 0);
    check(overflow == 1'b0, "R11", "overflow", overflow, 0);
    check(mem_we == 1'b0, "R11", "mem_we", mem_we, 0);

    send(0, 20'h00100, 32'hA0A0_0001, "R1");
    send(1, 20'h00200, 32'hB0B0_0001, "R2");
    send(1, 20'h00200, 32'hB0B0_0002, "R3");
    send(1, 20'h00200, 32'hB0B0_0003, "R3");
    @(negedge clk);
    check(mem_model[2] == 32'd3, "R3", "merged count", mem_model[2], 3);
    check(mem_model[3] == 32'h0900_0200, "R2", "indexed header", mem_model[3], 32'h0900_0200);
    send(1, 20'h00300, 32'hC0C0_0001, "R6");
    send(0, 20'h00300, 32'hC0C0_0002, "R5");
    send(1, 20'h00300, 32'hC0C0_0003, "R5");
    send(0, 20'h00400, 32'hD0D0_0001, "R4");
    for (int i = 0; m_ptr < D; i++) send(0, 20'h00500, 32'hE000_0000 + i, "R9");
    send(0, 20'h00600, 32'hF000_0001, "R9");
    send(1, 20'h00600, 32'hF000_0002, "R9");

    // R10 clear
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    #1;
    m_ptr = 0; m_start = 0; m_cnt = 0; m_open = 0; m_ovf = 0;
    check(fill_level == '0, "R10", "fill after clear", fill_level, 0);
    check(overflow == 1'b0, "R10", "overflow after clear", overflow, 0);
    send(1, 20'h00700, 32'h7700_0001, "R10");
    send(1, 20'h00700, 32'h7700_0002, "R3");
    @(negedge clk);
    check(mem_model[0] == 32'd2, "R10", "count at index 0", mem_model[0], 2);
    finish_run();
  end
endmodule